// File: doc/BRIEF.md
# PCI Subtractive Decode Controller

This block sits on the target side of a bridge from PCI to a slower expansion bus. It holds one 8-bit configuration control register. For each PCI cycle it decides whether the bridge claims the cycle positively, for the page-register ports, the system control port at 92h, the interrupt controller ports or an interrupt-acknowledge command. Otherwise it waits a software-selected number of clocks and, if no other agent has asserted DEVSEL#, it flags the cycle for subtractive forwarding to the secondary bus.

The register also drives the control lines of neighbouring logic: the interrupt-acknowledge response enable, the posted-write buffer enable and the two line-buffer mode bits. One register bit chooses whether the 90h–9Fh I/O range is claimed as an alias of the 80h–8Fh page registers or is left for the secondary bus. Port 92h is always decoded as a register of its own.

Top module: `pci_subdec_ctrl`

## Requirements
- R1: After a synchronous reset the control register holds 20h. `inta_resp_en` is 1, and `wbuf_en`, `isa_lb_8b`, `dma_lb_8b`, `claim_pos`, `claim_tgt`, `sub_fwd` and `cfg_rdata` are all 0.
- R2: A write with `cfg_addr`=40h stores `cfg_wdata[6:0]`, and bit 7 always reads as 0. A read at 40h returns the register on `cfg_rdata` one clock after the read edge. A read at any other offset returns 0, and a write at any other offset leaves the register unchanged.
- R3: Register bit 5 drives `inta_resp_en`, bit 2 drives `wbuf_en`, bit 1 drives `isa_lb_8b` and bit 0 drives `dma_lb_8b`. Each output changes on the same edge as the write that sets or clears its bit (1 = 8-byte mode for the two line-buffer bits).
- R4: An I/O command (`cyc_cmd` 2h read, 3h write) whose address has bits above 7 at zero is claimed with target code 1 (page) for addresses 80h–8Fh. The same code applies to 90h–9Fh other than 92h when register bit 6 is 0. When bit 6 is 1, those 90h–9Fh addresses are not claimed.
- R5: I/O address 92h is claimed with target code 2 whatever the value of register bit 6.
- R6: I/O addresses 20h, 21h, A0h and A1h are claimed with target code 3 whatever the value of bit 5. The interrupt-acknowledge command (`cyc_cmd` 0h) is claimed with target code 4 only when bit 5 is 1; otherwise it is neither claimed nor forwarded.
- R7: Register bits 4:3 set the sample point: 10 is the 1st clock after the address phase, 01 the 2nd, and 00 and 11 the 3rd. The value 11 reads back unchanged. The setting is captured at the address phase.
- R8: An unclaimed I/O or memory command (`cyc_cmd` 2h, 3h, 6h, 7h) with `devsel_n` high at every edge from N+1 to the sample point N+k raises `sub_fwd` for exactly one clock, from edge N+k on, where N is the edge that samples `cyc_start`. Other commands are never forwarded.
- R9: `sub_fwd` is never raised for a positively claimed cycle, nor for a cycle in which `devsel_n` was low at any edge N+1 to N+k.
- R10: `claim_pos` and `claim_tgt` (code 0 = none) are valid for the one clock that follows edge N and are 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Registered configuration read data |
| cyc_start | input | 1 | Address phase of a PCI cycle |
| cyc_cmd | input | 4 | PCI bus command |
| cyc_addr | input | ADDR_W | PCI address |
| devsel_n | input | 1 | DEVSEL# from other agents, active low |
| claim_pos | output | 1 | Positive claim, one clock |
| claim_tgt | output | 3 | Claimed target: 0 none, 1 page, 2 port 92h, 3 interrupt ports, 4 acknowledge |
| sub_fwd | output | 1 | Subtractive forward pulse |
| inta_resp_en | output | 1 | Interrupt-acknowledge response enable |
| wbuf_en | output | 1 | Posted write buffer enable |
| isa_lb_8b | output | 1 | Expansion-master line buffer in 8-byte mode |
| dma_lb_8b | output | 1 | DMA line buffer in 8-byte mode |

## Verification
A corrupt register bit appears at its control output on the very next clock, and in the read data one clock after a read. A wrong alias or enable bit changes `claim_tgt` one clock after the next address phase. A timer that counts from the wrong limit or misses a DEVSEL# assertion moves, drops or adds the `sub_fwd` pulse within three clocks of the address phase. The bench therefore compares every output against its model on every clock, so any such fault is caught within a few cycles.

// File: rtl/subdec_pkg.sv
package subdec_pkg;

  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_PAGE   = 3'd1,
    TGT_PORT92 = 3'd2,
    TGT_PIC    = 3'd3,
    TGT_INTA   = 3'd4
  } tgt_e;

  localparam logic [3:0] CMD_INTA = 4'h0;
  localparam logic [3:0] CMD_IORD = 4'h2;
  localparam logic [3:0] CMD_IOWR = 4'h3;
  localparam logic [3:0] CMD_MRD  = 4'h6;
  localparam logic [3:0] CMD_MWR  = 4'h7;

  localparam int BIT_ALIAS_OFF = 6;
  localparam int BIT_INTA_EN   = 5;
  localparam int BIT_SP_HI     = 4;
  localparam int BIT_SP_LO     = 3;
  localparam int BIT_WBUF      = 2;
  localparam int BIT_ISA_LB    = 1;
  localparam int BIT_DMA_LB    = 0;

  localparam logic [1:0] SP_SLOW = 2'b00;
  localparam logic [1:0] SP_TYP  = 2'b01;
  localparam logic [1:0] SP_FAST = 2'b10;

endpackage

// File: rtl/subdec_cfg_reg.sv
module subdec_cfg_reg #(
  parameter int         REG_W   = 8,
  parameter int         OFS_W   = 8,
  parameter logic [7:0] CFG_OFS = 8'h40,
  parameter logic [7:0] RST_VAL = 8'h20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] ctl
);

  localparam logic [REG_W-1:0] KEEP_MASK = {1'b0, {(REG_W-1){1'b1}}};

  logic hit;
  assign hit = (addr == OFS_W'(CFG_OFS));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl   <= REG_W'(RST_VAL) & KEEP_MASK;
      rdata <= '0;
    end else begin
      rdata <= (rd_en && hit) ? ctl : '0;
      if (wr_en && hit)
        ctl <= wdata & KEEP_MASK;
    end
  end

  // R2: reserved top bit never set, in storage or in read data
  a_r2_msb_zero: assert property (@(posedge clk) disable iff (rst)
    !ctl[REG_W-1] && !rdata[REG_W-1]);

  // R2: writes at a foreign offset leave the register alone
  a_r2_foreign_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hit) |=> $stable(ctl));

endmodule

// File: rtl/subdec_addr_decode.sv
module subdec_addr_decode
  import subdec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [3:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              alias_off,
  input  logic              inta_en,
  output tgt_e              tgt,
  output logic              fwd_ok
);

  logic hi_zero, is_io, is_mem;
  logic [7:0] lo;

  assign lo      = addr[7:0];
  assign hi_zero = (addr[ADDR_W-1:8] == '0);
  assign is_io   = (cmd == CMD_IORD) || (cmd == CMD_IOWR);
  assign is_mem  = (cmd == CMD_MRD)  || (cmd == CMD_MWR);

  always_comb begin
    tgt = TGT_NONE;
    if (is_io && hi_zero) begin
      if (lo == 8'h92)
        tgt = TGT_PORT92;
      else if (lo[7:4] == 4'h8)
        tgt = TGT_PAGE;
      else if (lo[7:4] == 4'h9 && !alias_off)
        tgt = TGT_PAGE;
      else if (lo[7:1] == 7'h10 || lo[7:1] == 7'h50)
        tgt = TGT_PIC;
    end else if (cmd == CMD_INTA && inta_en) begin
      tgt = TGT_INTA;
    end
  end

  assign fwd_ok = (is_io || is_mem) && (tgt == TGT_NONE);

endmodule

// File: rtl/subdec_sample_timer.sv
module subdec_sample_timer
  import subdec_pkg::*;
#(
  parameter int FAST_CLK = 1,
  parameter int TYP_CLK  = 2,
  parameter int SLOW_CLK = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       eligible,
  input  logic [1:0] sp_sel,
  input  logic       devsel_n,
  output logic       fwd
);

  localparam int CNT_W = $clog2(SLOW_CLK + 1);

  logic             active;
  logic [CNT_W-1:0] cnt, lim, sel_lim;

  always_comb begin
    case (sp_sel)
      SP_FAST: sel_lim = CNT_W'(FAST_CLK);
      SP_TYP:  sel_lim = CNT_W'(TYP_CLK);
      default: sel_lim = CNT_W'(SLOW_CLK);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      lim    <= '0;
      fwd    <= 1'b0;
    end else begin
      fwd <= 1'b0;
      if (start) begin
        active <= eligible;
        cnt    <= '0;
        lim    <= sel_lim;
      end else if (active) begin
        if (!devsel_n) begin
          active <= 1'b0;
        end else if ((cnt + CNT_W'(1)) == lim) begin
          fwd    <= 1'b1;
          active <= 1'b0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // R7: the elapsed count stays below the captured sample point
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt < lim));

  // R9: a claim by another agent while waiting kills the forward
  a_r9_drop_on_devsel: assert property (@(posedge clk) disable iff (rst)
    (active && !devsel_n && !start) |=> !fwd);

endmodule

// File: rtl/pci_subdec_ctrl.sv
module pci_subdec_ctrl
  import subdec_pkg::*;
#(
  parameter int         ADDR_W   = 32,
  parameter logic [7:0] CFG_OFS  = 8'h40,
  parameter logic [7:0] CFG_RST  = 8'h20,
  parameter int         FAST_CLK = 1,
  parameter int         TYP_CLK  = 2,
  parameter int         SLOW_CLK = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              cyc_start,
  input  logic [3:0]        cyc_cmd,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              devsel_n,
  output logic              claim_pos,
  output logic [2:0]        claim_tgt,
  output logic              sub_fwd,
  output logic              inta_resp_en,
  output logic              wbuf_en,
  output logic              isa_lb_8b,
  output logic              dma_lb_8b
);

  localparam int REG_W = 8;

  logic [REG_W-1:0] ctl;
  tgt_e             dec_tgt;
  logic             dec_fwd_ok;

  subdec_cfg_reg #(
    .REG_W   (REG_W),
    .OFS_W   (8),
    .CFG_OFS (CFG_OFS),
    .RST_VAL (CFG_RST)
  ) u_reg (
    .clk   (clk),
    .rst   (rst),
    .wr_en (cfg_wr),
    .rd_en (cfg_rd),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .ctl   (ctl)
  );

  subdec_addr_decode #(
    .ADDR_W (ADDR_W)
  ) u_dec (
    .cmd       (cyc_cmd),
    .addr      (cyc_addr),
    .alias_off (ctl[BIT_ALIAS_OFF]),
    .inta_en   (ctl[BIT_INTA_EN]),
    .tgt       (dec_tgt),
    .fwd_ok    (dec_fwd_ok)
  );

  subdec_sample_timer #(
    .FAST_CLK (FAST_CLK),
    .TYP_CLK  (TYP_CLK),
    .SLOW_CLK (SLOW_CLK)
  ) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .start    (cyc_start),
    .eligible (dec_fwd_ok),
    .sp_sel   (ctl[BIT_SP_HI:BIT_SP_LO]),
    .devsel_n (devsel_n),
    .fwd      (sub_fwd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      claim_pos <= 1'b0;
      claim_tgt <= TGT_NONE;
    end else begin
      claim_pos <= cyc_start && (dec_tgt != TGT_NONE);
      claim_tgt <= cyc_start ? dec_tgt : TGT_NONE;
    end
  end

  assign inta_resp_en = ctl[BIT_INTA_EN];
  assign wbuf_en      = ctl[BIT_WBUF];
  assign isa_lb_8b    = ctl[BIT_ISA_LB];
  assign dma_lb_8b    = ctl[BIT_DMA_LB];

  // R10: a claim only follows an address phase
  a_r10_claim_after_start: assert property (@(posedge clk) disable iff (rst)
    claim_pos |-> $past(cyc_start));

  // R9: forwarding and positive claim never coincide
  a_r9_no_fwd_with_claim: assert property (@(posedge clk) disable iff (rst)
    sub_fwd |-> !claim_pos);

  // R9: forwarding needs DEVSEL# idle at the sample edge
  a_r9_fwd_idle_devsel: assert property (@(posedge clk) disable iff (rst)
    sub_fwd |-> $past(devsel_n));

  // R8: forward is a single-clock pulse
  a_r8_fwd_pulse: assert property (@(posedge clk) disable iff (rst)
    sub_fwd |=> !sub_fwd);

  // R6: acknowledge claimed only with the enable set
  a_r6_inta_gate: assert property (@(posedge clk) disable iff (rst)
    (claim_tgt == TGT_INTA) |-> $past(inta_resp_en));

  // R5: port 92h code always comes with a claim
  a_r5_port92_claimed: assert property (@(posedge clk) disable iff (rst)
    (claim_tgt == TGT_PORT92) |-> claim_pos);

endmodule

// File: tb/tb_pci_subdec_ctrl.sv
module tb_pci_subdec_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [7:0]  cfg_addr = 8'h0, cfg_wdata = 8'h0;
  logic [7:0]  cfg_rdata;
  logic        cyc_start = 1'b0;
  logic [3:0]  cyc_cmd = 4'h0;
  logic [31:0] cyc_addr = 32'h0;
  logic        devsel_n = 1'b1;
  logic        claim_pos, sub_fwd, inta_resp_en, wbuf_en, isa_lb_8b, dma_lb_8b;
  logic [2:0]  claim_tgt;

  int n_cmp = 0, n_bad = 0;
  bit chk_on = 0, done = 0;

  always #4 clk = ~clk;

  pci_subdec_ctrl dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cyc_start(cyc_start), .cyc_cmd(cyc_cmd), .cyc_addr(cyc_addr),
    .devsel_n(devsel_n), .claim_pos(claim_pos), .claim_tgt(claim_tgt),
    .sub_fwd(sub_fwd), .inta_resp_en(inta_resp_en), .wbuf_en(wbuf_en),
    .isa_lb_8b(isa_lb_8b), .dma_lb_8b(dma_lb_8b)
  );

  // Reference model state
  int m_reg, m_rd, m_claim, m_tgt, m_fwd, remain;

  function automatic int exp_tgt(int cmd, longint a, int r);
    bit io = (cmd == 2) || (cmd == 3);
    if (io && a < 256) begin
      if (a == 146) return 2;
      if (a >= 128 && a <= 143) return 1;
      if (a >= 144 && a <= 159 && ((r / 64) % 2) == 0) return 1;
      if (a == 32 || a == 33 || a == 160 || a == 161) return 3;
      return 0;
    end
    if (cmd == 0 && ((r / 32) % 2) == 1) return 4;
    return 0;
  endfunction

  function automatic int exp_lim(int r);
    int code = (r / 8) % 4;
    if (code == 2) return 1;
    if (code == 1) return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    chk_on <= 1;
    if (rst) begin
      m_reg = 32; m_rd = 0; m_claim = 0; m_tgt = 0; m_fwd = 0; remain = 0;
    end else begin
      int t;
      int c;
      m_fwd = 0;
      c = int'(cyc_cmd);
      t = exp_tgt(c, longint'(cyc_addr), m_reg);
      if (cyc_start) begin
        remain = ((c == 2 || c == 3 || c == 6 || c == 7) && t == 0) ? exp_lim(m_reg) : 0;
      end else if (remain > 0) begin
        if (!devsel_n) remain = 0;
        else begin
          remain = remain - 1;
          if (remain == 0) m_fwd = 1;
        end
      end
      m_claim = (cyc_start && t != 0) ? 1 : 0;
      m_tgt   = cyc_start ? t : 0;
      m_rd    = (cfg_rd && cfg_addr == 8'h40) ? m_reg : 0;
      if (cfg_wr && cfg_addr == 8'h40) m_reg = int'(cfg_wdata) % 128;
    end
  end

  task automatic cmp(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // Compare every output on every falling edge
  always @(negedge clk) begin
    if (chk_on && !done) begin
      string pre;
      pre = rst ? "R1 " : "";
      cmp({pre, "R2/R7 cfg_rdata"}, int'(cfg_rdata), m_rd);
      cmp({pre, "R10 claim_pos"}, int'(claim_pos), m_claim);
      cmp({pre, "R4/R5/R6 claim_tgt"}, int'(claim_tgt), m_tgt);
      cmp({pre, "R8/R9 sub_fwd"}, int'(sub_fwd), m_fwd);
      cmp({pre, "R3 inta_resp_en"}, int'(inta_resp_en), (m_reg / 32) % 2);
      cmp({pre, "R3 wbuf_en"}, int'(wbuf_en), (m_reg / 4) % 2);
      cmp({pre, "R3 isa_lb_8b"}, int'(isa_lb_8b), (m_reg / 2) % 2);
      cmp({pre, "R3 dma_lb_8b"}, int'(dma_lb_8b), m_reg % 2);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); cfg_rd = 1; cfg_addr = a;
    @(negedge clk); cfg_rd = 0;
  endtask

  // claim_at: edge offset (1..4) where another agent drives DEVSEL#, 0 = never
  task automatic cyc(input logic [3:0] cmd, input logic [31:0] a, input int claim_at);
    @(negedge clk); cyc_start = 1; cyc_cmd = cmd; cyc_addr = a; devsel_n = 1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk); cyc_start = 0; devsel_n = (k == claim_at) ? 1'b0 : 1'b1;
    end
    @(negedge clk); devsel_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;                                   // R1 reset state compared above
    rd(8'h40);                                 // R2 reads 20h
    rd(8'h41);                                 // R2 foreign read gives 0
    wr(8'h40, 8'hFF); rd(8'h40);               // R2 bit 7 dropped, R3 outputs high
    wr(8'h41, 8'h00); rd(8'h40);               // R2 foreign write ignored
    wr(8'h40, 8'h18); rd(8'h40);               // R7 code 11 reads back
    // R7/R8/R9: every sample point, claims at each clock
    for (int sp = 0; sp < 4; sp++) begin
      wr(8'h40, 8'(sp * 8));
      for (int ca = 0; ca <= 4; ca++) begin
        cyc(4'h3, 32'h0000_0300, ca);          // unclaimed I/O
        cyc(4'h6, 32'h1000_0000, ca);          // unclaimed memory
      end
      cyc(4'hA, 32'h0, 0);                     // R8 config command never forwarded
    end
    // R4/R5 aliasing boundaries in both modes, R9 claimed never forwarded
    for (int al = 0; al < 2; al++) begin
      wr(8'h40, 8'(al * 64 + 16));
      cyc(4'h2, 32'h80, 0);
      cyc(4'h2, 32'h8F, 0);
      cyc(4'h3, 32'h90, 0);
      cyc(4'h2, 32'h92, 0);
      cyc(4'h3, 32'h9F, 0);
      cyc(4'h2, 32'hA0, 0);
      cyc(4'h2, 32'h1092, 0);                  // R4 upper bits set: not claimed
    end
    // R6 acknowledge and interrupt ports with enable clear and set
    for (int en = 0; en < 2; en++) begin
      wr(8'h40, 8'(en * 32));
      cyc(4'h0, 32'h0, 0);
      cyc(4'h2, 32'h20, 0);
      cyc(4'h3, 32'h21, 0);
      cyc(4'h2, 32'hA1, 0);
      cyc(4'h2, 32'h22, 0);
    end
    // R3 individual control bits
    wr(8'h40, 8'h04); wr(8'h40, 8'h02); wr(8'h40, 8'h01); wr(8'h40, 8'h00);
    // R1 reset mid-run restores defaults
    wr(8'h40, 8'h5F);
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    rd(8'h40);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule